// File: doc/BRIEF.md
# NOR Flash Identification Probe

This block identifies a parallel NOR flash device attached to an asynchronous bus and works out its geometry, with no software involvement. A one-cycle start pulse launches a fixed bus programme. Three unlock and autoselect command writes go out first, in a form that both common command sets accept. A settle wait follows. The block then reads the manufacturer code at word 0 and the device code at word 1. When the device is recognised, one exit command returns the flash to array-read mode.

The results stay registered until the next start: the command-set class, a device index, the sector count and the total size in bytes. A combinational lookup port turns a sector number into the start offset of that sector. It covers both the bottom-boot layout, where small boot sectors are followed by large ones, and the uniform layout. Each command byte is copied into every byte lane of the bus word, so that paired narrow devices receive the command together. Every bus access is a fixed-length strobe followed by one idle recovery cycle.

Top module: `nor_id_probe`

## Requirements
- R1: After an accepted start, the first three bus cycles are writes, in this order: 0xAA to word 0x555, then 0x55 to word 0x2AA, then 0x90 to word 0x555. Each byte is replicated into every byte lane of the data word (0xAAAA on a 16-bit bus).
- R2: After the write strobe of the third command ends, no read strobe begins for at least SETTLE_CYC clock cycles.
- R3: The first read is at word 0, and only its low byte is used. A value of 0x01 selects command-set code 1 (unlock-cycle set) and 0x89 selects code 2 (status-register set). Any other value ends the probe with unknown_o=1 and with cmdset_o, dev_idx_o, sect_cnt_o and size_o all 0, and no further bus cycle is made.
- R4: For a known manufacturer, the second read is at word 1 and is compared over the full bus width, with the 16-bit code repeated in every 16-bit half. The codes map as follows (index/sectors/size in MiB on a 16-bit bus): 0x22D7→1/128/8 uniform; 0x88C1→2/23/1; 0x8893→3/23/1; 0x88C3→4/39/2; 0x8891→5/39/2; 0x88C5→6/71/4; 0x8897→7/71/4; 0x88CD→8/135/8; 0x8899→9/135/8. Indices 2 to 9 are bottom-boot parts. Any other code ends the probe as unknown, with all results 0.
- R5: size_o gives the size in bytes (MiB × 2^20), multiplied by DATA_W/16. It is 0 exactly when sect_cnt_o is 0.
- R6: On a bottom-boot device, sector i < 8 starts at BASE_ADDR + i×0x2000×(DATA_W/16). Sector i ≥ 8 starts at BASE_ADDR + (i−7)×0x10000×(DATA_W/16).
- R7: On the uniform device, sector i starts at BASE_ADDR + i×0x10000×(DATA_W/16). On any device, a sector number at or above the sector count gives an offset of 0, and so does any sector number when no device is known.
- R8: After a recognised device, the last bus cycle is a write to word 0: 0xF0 replicated for command-set code 1, or 0xFF replicated for code 2. An unknown result produces no exit write.
- R9: fl_ce_no is low whenever fl_we_no or fl_oe_no is low, and fl_we_no and fl_oe_no are never low together. Each strobe lasts STROBE_CYC cycles, with address and data held steady. Every strobe is followed by at least one cycle with all three controls high.
- R10: busy_o is high from the cycle after an accepted start until completion, and start_i is ignored while busy_o is high. done_o rises at completion and stays high, with all results held, until the next start; busy_o and done_o are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while busy |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | Probe finished, results valid |
| unknown_o | output | 1 | Probe finished without a recognised device |
| cmdset_o | output | 2 | 0 none, 1 unlock-cycle set, 2 status-register set |
| dev_idx_o | output | 4 | Device index, 0 when unknown |
| sect_cnt_o | output | 8 | Number of sectors |
| size_o | output | OFS_W | Device size in bytes |
| sect_sel_i | input | 8 | Sector number to look up |
| sect_ofs_o | output | OFS_W | Start offset of the selected sector |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_wdata_o | output | DATA_W | Flash write data |
| fl_rdata_i | input | DATA_W | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write strobe, active low |
| fl_oe_no | output | 1 | Output enable, active low |

## Verification
A sequencer that skips or reorders a phase shows up at the bus on the next strobe. The wrong address or data appears at the falling edge of a write, or a read starts early, inside the settle window. A classification fault only becomes visible when done_o rises, as a wrong count, size, index or command-set code. It can also show as a missing or wrong exit write. A wrong sector-map term shows on sect_ofs_o in the same cycle the sector number is applied. Lookups are therefore swept across the boot and main boundary and beyond the last sector.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  typedef enum logic [1:0] {
    CMDSET_NONE   = 2'd0,
    CMDSET_UNLOCK = 2'd1,
    CMDSET_STATUS = 2'd2
  } cmdset_e;

  localparam logic [7:0] MFR_UNLOCK   = 8'h01;
  localparam logic [7:0] MFR_STATUS   = 8'h89;
  localparam logic [7:0] CMD_KEY_A    = 8'hAA;
  localparam logic [7:0] CMD_KEY_B    = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
  localparam logic [7:0] CMD_EXIT_UNL = 8'hF0;
  localparam logic [7:0] CMD_EXIT_STS = 8'hFF;
  localparam int unsigned KEY_ADDR_A  = 'h555;
  localparam int unsigned KEY_ADDR_B  = 'h2AA;

  typedef struct packed {
    logic       known;
    logic [3:0] idx;
    logic [7:0] sectors;
    logic [3:0] mbytes;  // MiB on a 16-bit bus
    logic       boot;
  } geom_t;

  function automatic geom_t lookup_dev(input logic [15:0] code);
    geom_t g;
    g = '0;
    case (code)
      16'h22D7: g = '{1'b1, 4'd1, 8'd128, 4'd8, 1'b0};
      16'h88C1: g = '{1'b1, 4'd2, 8'd23,  4'd1, 1'b1};
      16'h8893: g = '{1'b1, 4'd3, 8'd23,  4'd1, 1'b1};
      16'h88C3: g = '{1'b1, 4'd4, 8'd39,  4'd2, 1'b1};
      16'h8891: g = '{1'b1, 4'd5, 8'd39,  4'd2, 1'b1};
      16'h88C5: g = '{1'b1, 4'd6, 8'd71,  4'd4, 1'b1};
      16'h8897: g = '{1'b1, 4'd7, 8'd71,  4'd4, 1'b1};
      16'h88CD: g = '{1'b1, 4'd8, 8'd135, 4'd8, 1'b1};
      16'h8899: g = '{1'b1, 4'd9, 8'd135, 4'd8, 1'b1};
      default:  g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/nor_bus_strobe.sv
module nor_bus_strobe #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REC} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      wr_q       <= 1'b0;
      fl_addr_o  <= '0;
      fl_wdata_o <= '0;
      rdata_o    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          st_q       <= ST_ACT;
          cnt_q      <= '0;
          wr_q       <= wr_i;
          fl_addr_o  <= addr_i;
          fl_wdata_o <= wr_i ? wdata_i : '0;
        end
        ST_ACT: begin
          if (cnt_q == CNT_W'(STROBE_CYC - 1)) begin
            st_q <= ST_REC;
            if (!wr_q) rdata_o <= fl_rdata_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REC:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fl_ce_no = (st_q != ST_ACT);
  assign fl_we_no = !((st_q == ST_ACT) && wr_q);
  assign fl_oe_no = !((st_q == ST_ACT) && !wr_q);
  assign ack_o    = (st_q == ST_REC);

endmodule

// File: rtl/nor_id_classify.sv
module nor_id_classify
  import nor_probe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_i,
  output cmdset_e           cmdset_o,
  output geom_t             geom_o
);
  localparam int LANES = DATA_W / 16;

  logic [LANES-1:0] lane_eq;

  // device code must repeat in every 16-bit half of the bus word
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (word_i[l*16 +: 16] == word_i[15:0]);
  end

  always_comb begin
    case (word_i[7:0])
      MFR_UNLOCK: cmdset_o = CMDSET_UNLOCK;
      MFR_STATUS: cmdset_o = CMDSET_STATUS;
      default:    cmdset_o = CMDSET_NONE;
    endcase
    geom_o = (&lane_eq) ? lookup_dev(word_i[15:0]) : '0;
  end

endmodule

// File: rtl/nor_sector_map.sv
module nor_sector_map #(
  parameter int              DATA_W    = 16,
  parameter int              OFS_W     = 32,
  parameter logic [OFS_W-1:0] BASE_ADDR = '0
) (
  input  logic             valid_i,
  input  logic             boot_i,
  input  logic [7:0]       sectors_i,
  input  logic [7:0]       sel_i,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int              SCALE  = DATA_W / 16;
  localparam int              BOOT_N = 8;
  localparam logic [OFS_W-1:0] BOOT_B = OFS_W'(32'h2000 * SCALE);
  localparam logic [OFS_W-1:0] MAIN_B = OFS_W'(32'h10000 * SCALE);

  always_comb begin
    ofs_o = '0;
    if (valid_i && (sel_i < sectors_i)) begin
      if (boot_i && (sel_i < 8'(BOOT_N)))
        ofs_o = BASE_ADDR + OFS_W'(sel_i) * BOOT_B;
      else if (boot_i)
        ofs_o = BASE_ADDR + OFS_W'(sel_i - 8'(BOOT_N - 1)) * MAIN_B;
      else
        ofs_o = BASE_ADDR + OFS_W'(sel_i) * MAIN_B;
    end
  end

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_probe_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              ADDR_W     = 22,
  parameter int              STROBE_CYC = 3,
  parameter int              SETTLE_CYC = 12500,
  parameter int              OFS_W      = 32,
  parameter logic [OFS_W-1:0] BASE_ADDR  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unknown_o,
  output logic [1:0]        cmdset_o,
  output logic [3:0]        dev_idx_o,
  output logic [7:0]        sect_cnt_o,
  output logic [OFS_W-1:0]  size_o,
  input  logic [7:0]        sect_sel_i,
  output logic [OFS_W-1:0]  sect_ofs_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);
  localparam int BL       = DATA_W / 8;
  localparam int SCALE_SH = $clog2(DATA_W / 16);
  localparam int SET_W    = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {P_IDLE, P_KEY1, P_KEY2, P_AUTO, P_SETTLE, P_MFR, P_DEV, P_EXIT} ph_e;

  ph_e               ph_q;
  logic [SET_W-1:0]  set_q;
  cmdset_e           cs_q;
  geom_t             geom_q;
  logic              done_q, unk_q;

  logic              op_req, op_wr, op_ack;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata, op_rdata;
  cmdset_e           cls_cs;
  geom_t             cls_geom;

  always_comb begin
    op_req   = 1'b1;
    op_wr    = 1'b1;
    op_addr  = '0;
    op_wdata = '0;
    case (ph_q)
      P_KEY1: begin op_addr = ADDR_W'(KEY_ADDR_A); op_wdata = {BL{CMD_KEY_A}};   end
      P_KEY2: begin op_addr = ADDR_W'(KEY_ADDR_B); op_wdata = {BL{CMD_KEY_B}};   end
      P_AUTO: begin op_addr = ADDR_W'(KEY_ADDR_A); op_wdata = {BL{CMD_AUTOSEL}}; end
      P_MFR:  op_wr = 1'b0;
      P_DEV:  begin op_wr = 1'b0; op_addr = ADDR_W'(1); end
      P_EXIT: op_wdata = (cs_q == CMDSET_STATUS) ? {BL{CMD_EXIT_STS}} : {BL{CMD_EXIT_UNL}};
      default: begin op_req = 1'b0; op_wr = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= P_IDLE;
      set_q  <= '0;
      cs_q   <= CMDSET_NONE;
      geom_q <= '0;
      done_q <= 1'b0;
      unk_q  <= 1'b0;
    end else begin
      case (ph_q)
        P_IDLE: if (start_i) begin
          ph_q   <= P_KEY1;
          done_q <= 1'b0;
          unk_q  <= 1'b0;
          cs_q   <= CMDSET_NONE;
          geom_q <= '0;
        end
        P_KEY1: if (op_ack) ph_q <= P_KEY2;
        P_KEY2: if (op_ack) ph_q <= P_AUTO;
        P_AUTO: if (op_ack) begin ph_q <= P_SETTLE; set_q <= '0; end
        P_SETTLE: begin
          if (set_q == SET_W'(SETTLE_CYC - 1)) ph_q <= P_MFR;
          else set_q <= set_q + 1'b1;
        end
        P_MFR: if (op_ack) begin
          if (cls_cs == CMDSET_NONE) begin
            ph_q <= P_IDLE; done_q <= 1'b1; unk_q <= 1'b1;
          end else begin
            cs_q <= cls_cs; ph_q <= P_DEV;
          end
        end
        P_DEV: if (op_ack) begin
          if (!cls_geom.known) begin
            ph_q <= P_IDLE; done_q <= 1'b1; unk_q <= 1'b1; cs_q <= CMDSET_NONE;
          end else begin
            geom_q <= cls_geom; ph_q <= P_EXIT;
          end
        end
        P_EXIT: if (op_ack) begin ph_q <= P_IDLE; done_q <= 1'b1; end
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  nor_bus_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(op_req), .wr_i(op_wr), .addr_i(op_addr), .wdata_i(op_wdata),
    .ack_o(op_ack), .rdata_o(op_rdata),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i),
    .fl_ce_no(fl_ce_no), .fl_we_no(fl_we_no), .fl_oe_no(fl_oe_no)
  );

  nor_id_classify #(.DATA_W(DATA_W)) u_classify (
    .word_i(op_rdata), .cmdset_o(cls_cs), .geom_o(cls_geom)
  );

  nor_sector_map #(.DATA_W(DATA_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)) u_map (
    .valid_i(geom_q.known), .boot_i(geom_q.boot), .sectors_i(geom_q.sectors),
    .sel_i(sect_sel_i), .ofs_o(sect_ofs_o)
  );

  assign busy_o     = (ph_q != P_IDLE);
  assign done_o     = done_q;
  assign unknown_o  = unk_q;
  assign cmdset_o   = cs_q;
  assign dev_idx_o  = geom_q.idx;
  assign sect_cnt_o = geom_q.sectors;
  assign size_o     = OFS_W'(geom_q.mbytes) << (20 + SCALE_SH);

endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int OFS_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              unknown_o,
  input logic [1:0]        cmdset_o,
  input logic [3:0]        dev_idx_o,
  input logic [7:0]        sect_cnt_o,
  input logic [OFS_W-1:0]  size_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [DATA_W-1:0] fl_wdata_o,
  input logic              fl_ce_no,
  input logic              fl_we_no,
  input logic              fl_oe_no
);
  a_r9_strobe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));

  a_r9_strobe_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);

  a_r9_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  a_r9_no_bus_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> fl_ce_no);

  a_r3_unknown_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unknown_o |-> (sect_cnt_o == 8'd0 && size_o == '0 && cmdset_o == 2'd0 && dev_idx_o == 4'd0));

  a_r5_size_tracks_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sect_cnt_o == 8'd0) == (size_o == '0));

  a_r10_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(sect_cnt_o) && $stable(size_o) &&
                              $stable(cmdset_o) && $stable(dev_idx_o)));

endmodule

bind nor_id_probe nor_id_probe_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .unknown_o(unknown_o), .cmdset_o(cmdset_o), .dev_idx_o(dev_idx_o), .sect_cnt_o(sect_cnt_o),
  .size_o(size_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_ce_no(fl_ce_no),
  .fl_we_no(fl_we_no), .fl_oe_no(fl_oe_no)
);

// File: tb/nor_id_probe_tb_top.sv
module nor_id_probe_tb_top;
  localparam int DW     = 16;
  localparam int AW     = 22;
  localparam int STROBE = 2;
  localparam int SETTLE = 20;
  localparam int OW     = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, unk;
  logic [1:0]    cs;
  logic [3:0]    idx;
  logic [7:0]    cnt;
  logic [OW-1:0] size, ofs;
  logic [7:0]    sel = 8'd0;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic          fl_ce_n, fl_we_n, fl_oe_n;

  always #4 clk = ~clk;

  nor_id_probe #(.DATA_W(DW), .ADDR_W(AW), .STROBE_CYC(STROBE), .SETTLE_CYC(SETTLE), .OFS_W(OW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done), .unknown_o(unk),
    .cmdset_o(cs), .dev_idx_o(idx), .sect_cnt_o(cnt), .size_o(size), .sect_sel_i(sel),
    .sect_ofs_o(ofs), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata),
    .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural flash: identifier mode entered by the autoselect write
  logic          id_mode = 1'b0;
  logic [15:0]   mfr_w = 16'h0, dev_w = 16'h0;
  always_comb begin
    if (id_mode) fl_rdata = (fl_addr == 0) ? mfr_w : (fl_addr == 1) ? dev_w : 16'h0000;
    else         fl_rdata = 16'hFFFF;
  end

  typedef struct packed { logic wr; logic [AW-1:0] addr; logic [DW-1:0] data; } ev_t;
  ev_t exp_q[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic take_ev(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ev_t e;
    compared++;
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL R1/R8 unexpected bus cycle actual=%0h:%0h:%0h expected=none", wr, a, d);
    end else begin
      e = exp_q.pop_front();
      if (e.wr !== wr || e.addr !== a || (wr && e.data !== d)) begin
        mismatched++;
        $display("FAIL R1/R3/R4/R8 bus cycle actual=%0h:%0h:%0h expected=%0h:%0h:%0h",
                 wr, a, d, e.wr, e.addr, e.data);
      end
    end
  endtask

  // per-clock bus monitor and reference comparison
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int   we_rise_cyc = 0;
  bit   await_read = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      compared++;
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) begin
        mismatched++; $display("FAIL R9 strobe without ce actual=1 expected=0");
      end
      compared++;
      if (!fl_we_n && !fl_oe_n) begin
        mismatched++; $display("FAIL R9 both strobes low actual=1 expected=0");
      end
      if (prev_we && !fl_we_n) begin
        take_ev(1'b1, fl_addr, fl_wdata);
        if (fl_wdata == 16'h9090) begin id_mode = 1'b1; await_read = 1; end
        if (fl_wdata == 16'hF0F0 || fl_wdata == 16'hFFFF) id_mode = 1'b0;
      end
      if (!prev_we && fl_we_n) we_rise_cyc = cyc;
      if (prev_oe && !fl_oe_n) begin
        take_ev(1'b0, fl_addr, '0);
        if (await_read) begin
          chk("R2 settle gap >= SETTLE_CYC", ((cyc - we_rise_cyc) >= SETTLE) ? 1 : 0, 1);
          await_read = 0;
        end
      end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic push_ev(input logic wr, input int a, input logic [15:0] d);
    ev_t e;
    e.wr = wr; e.addr = AW'(a); e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic probe(input logic [15:0] mw, input logic [15:0] dw,
                       input int e_cs, input int e_idx, input int e_cnt, input longint e_size,
                       input bit poke_busy);
    bit mk, dk;
    mk = (e_cs != 0) || (mw[7:0] == 8'h01) || (mw[7:0] == 8'h89);
    dk = (e_idx != 0);
    mfr_w = mw; dev_w = dw;
    push_ev(1'b1, 'h555, 16'hAAAA);
    push_ev(1'b1, 'h2AA, 16'h5555);
    push_ev(1'b1, 'h555, 16'h9090);
    push_ev(1'b0, 0, 16'h0);
    if (mk) push_ev(1'b0, 1, 16'h0);
    if (dk) push_ev(1'b1, 0, (e_cs == 2) ? 16'hFFFF : 16'hF0F0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 busy after start", busy, 1);
    chk("R10 done cleared by start", done, 0);
    if (poke_busy) begin
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R10 start ignored while busy", busy, 1);
    end
    while (!done) @(negedge clk);
    chk("R10 busy low at done", busy, 0);
    chk("R3 unknown flag", unk, (e_idx == 0) ? 1 : 0);
    chk("R3 cmdset code", cs, e_cs);
    chk("R4 device index", idx, e_idx);
    chk("R4 sector count", cnt, e_cnt);
    chk("R5 size bytes", size, e_size);
    chk("R1/R8 all expected bus cycles seen", exp_q.size(), 0);
    chk("R8 flash left in read mode", id_mode, (dk || !mk) ? ((dk) ? 0 : 1) : 1);
    repeat (5) @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R1/R8 no bus cycle after done", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic look(input int s, input longint e);
    sel = 8'(s);
    #1;
    chk($sformatf("R6/R7 sector %0d offset", s), ofs, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R9 reset ce", fl_ce_n, 1);
    chk("R9 reset we/oe", {fl_we_n, fl_oe_n}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 lookup with no device", ofs, 0);

    // uniform part, unlock-cycle set; manufacturer high byte ignored (R3)
    probe(16'hAB01, 16'h22D7, 1, 1, 128, 64'h800000, 1'b0);
    look(0, 0); look(5, 64'h50000); look(127, 64'h7F0000); look(128, 0);

    // bottom-boot 8 Mbit, status set
    probe(16'h0089, 16'h88C1, 2, 2, 23, 64'h100000, 1'b1);
    look(0, 0); look(1, 64'h2000); look(7, 64'hE000); look(8, 64'h10000);
    look(22, 64'hF0000); look(23, 0);

    probe(16'h0089, 16'h8891, 2, 5, 39, 64'h200000, 1'b0);
    look(38, 64'h1F0000);
    probe(16'h0001, 16'h8897, 1, 7, 71, 64'h400000, 1'b0);
    look(70, 64'h3F0000);
    probe(16'h0089, 16'h8899, 2, 9, 135, 64'h800000, 1'b0);
    look(134, 64'h7F0000); look(9, 64'h20000);

    // unknown manufacturer: no device read, no exit write (R3)
    probe(16'h00C2, 16'h22D7, 0, 0, 0, 0, 1'b0);
    look(0, 0);
    // unknown device code (R4)
    probe(16'h0089, 16'h1234, 0, 0, 0, 0, 1'b0);
    // recovery probe after unknown
    probe(16'h0089, 16'h88CD, 2, 8, 135, 64'h800000, 1'b0);
    look(7, 64'hE000);

    finished = 1;
    summary();
  end

endmodule